// File: doc/BRIEF.md
# Divergent Branch Lane Mask Stack

This block controls lane activity for a small SIMD lane array in which every lane executes the same instruction in the same cycle on its own registers. When lanes disagree on a branch, the block serializes the two paths. The lanes whose condition is true run the taken path first while the others wait. Then the lanes whose condition was false run the other path while the first group waits. At the join, the mask that was in force before the branch comes back. The active mask it drives gates only the per-lane register write-back: a lane whose bit is clear executes the instruction but must not commit a result.

The instruction decoder issues four commands:
- Branch-open comes with the per-lane compare result.
- Switch-to-alternate turns the mask over to the lanes that were false.
- Join restores the earlier mask.
- Idle leaves everything as it is.

Nested conditionals are held on a bounded LIFO, so an N-way divergence is issued as N sequential paths. When a path has no active lane, a skip indication lets the decoder jump over it. Misuse of the stack latches an error flag that clears only on reset.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the error flag is low, skip is low and the stack is empty.
- R2: A branch-open command (cmd_i = 2'b01) with the stack not full saves the current mask and the condition on the stack. From the next cycle the active mask is the old mask AND cond_i.
- R3: A switch-to-alternate command (cmd_i = 2'b10) with a non-empty stack sets the mask to the saved mask AND NOT the saved condition of the top entry.
- R4: A join command (cmd_i = 2'b11) with a non-empty stack restores the top entry's saved mask and removes that entry.
- R5: skip_o is high exactly when the active mask has no lane set.
- R6: Conditionals nest up to STACK_DEPTH levels. Each join returns the mask of the enclosing level.
- R7: A branch-open while STACK_DEPTH entries are held sets the error flag and leaves the mask, skip and stack contents unchanged.
- R8: A join or switch-to-alternate while the stack is empty sets the error flag and leaves the mask unchanged.
- R9: The error flag stays high until reset, whatever commands follow.
- R10: An idle command (cmd_i = 2'b00) holds the active mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | 00 idle, 01 branch-open, 10 switch-to-alternate, 11 join |
| cond_i | input | NUM_LANES | Per-lane compare result, used with branch-open |
| active_mask_o | output | NUM_LANES | Lanes allowed to write back |
| skip_o | output | 1 | No lane active on the current path |
| err_o | output | 1 | Sticky stack misuse flag |

## Verification
Two functions can land in the same cycle: the empty-path skip and the overflow error. The bench nests branches to full depth so that the innermost mask becomes zero. It then issues one more branch-open. It requires that the error flag rises while the mask stays at zero and skip stays high. It then requires that the four following joins return each enclosing mask in order, with the error flag still held.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PUSH = 2'b01,
    CMD_ELSE = 2'b10,
    CMD_POP  = 2'b11
  } cmd_e;
endpackage

// File: rtl/simt_lifo.sv
module simt_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  top_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  stk_q [DEPTH];
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_q <= '0;
    else if (push_i && !full_o) count_q <= count_q + 1'b1;
    else if (pop_i && !empty_o) count_q <= count_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stk_q[g] <= '0;
      else if (push_i && count_q == CW'(g)) stk_q[g] <= wdata_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (count_q == CW'(i + 1)) top_o = stk_q[i];
  end

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;

  assert_depth_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_pop_decrements_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/simt_mask_calc.sv
module simt_mask_calc
  import simt_pkg::*;
#(
  parameter int N = 8
) (
  input  cmd_e         cmd_i,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] saved_i,
  input  logic [N-1:0] saved_cond_i,
  input  logic         full_i,
  input  logic         empty_i,
  output logic [N-1:0] nxt_o,
  output logic         push_o,
  output logic         pop_o,
  output logic         bad_o
);
  always_comb begin
    nxt_o  = cur_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    bad_o  = 1'b0;
    unique case (cmd_i)
      CMD_PUSH: begin
        if (full_i) bad_o = 1'b1;
        else begin
          push_o = 1'b1;
          nxt_o  = cur_i & cond_i;
        end
      end
      CMD_ELSE: begin
        if (empty_i) bad_o = 1'b1;
        else nxt_o = saved_i & ~saved_cond_i;
      end
      CMD_POP: begin
        if (empty_i) bad_o = 1'b1;
        else begin
          pop_o = 1'b1;
          nxt_o = saved_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_pkg::*;
#(
  parameter int NUM_LANES   = 8,
  parameter int STACK_DEPTH = 4,
  localparam int EW = 2 * NUM_LANES,
  localparam int CW = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           cmd_i,
  input  logic [NUM_LANES-1:0] cond_i,
  output logic [NUM_LANES-1:0] active_mask_o,
  output logic                 skip_o,
  output logic                 err_o
);
  cmd_e                 cmd;
  logic [NUM_LANES-1:0] mask_q, mask_d, saved, saved_cond;
  logic [EW-1:0]        top;
  logic                 push, pop, bad, full, empty, err_q;
  logic [CW-1:0]        count;

  assign cmd = cmd_e'(cmd_i);
  assign {saved, saved_cond} = top;

  simt_mask_calc #(.N(NUM_LANES)) u_calc (
    .cmd_i(cmd), .cur_i(mask_q), .cond_i(cond_i),
    .saved_i(saved), .saved_cond_i(saved_cond),
    .full_i(full), .empty_i(empty),
    .nxt_o(mask_d), .push_o(push), .pop_o(pop), .bad_o(bad)
  );

  // entry = {mask before branch, branch condition}
  simt_lifo #(.W(EW), .DEPTH(STACK_DEPTH)) u_lifo (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .wdata_i({mask_q, cond_i}), .top_o(top),
    .empty_o(empty), .full_o(full), .count_o(count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (bad) err_q <= 1'b1;
    end
  end

  assign active_mask_o = mask_q;
  assign skip_o        = ~|mask_q;
  assign err_o         = err_q;

  assert_push_subset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PUSH && !full) |=> (mask_q & ~$past(mask_q)) == '0);
  assert_pop_restore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_POP && !empty) |=> mask_q == $past(saved));
  assert_skip_in_branch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> count != '0);
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PUSH && full) |=> $stable(mask_q) && err_q);
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd == CMD_POP || cmd == CMD_ELSE) && empty) |=> $stable(mask_q) && err_q);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_nop_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_NOP |=> $stable(mask_q));
endmodule

// File: tb/simt_mask_stack_test.sv
module simt_mask_stack_test;
  localparam int N = 8;
  logic         clk = 0, rst_n = 0;
  logic [1:0]   cmd = 2'b00;
  logic [N-1:0] cond = '0;
  logic [N-1:0] mask;
  logic         skip, err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simt_mask_stack #(.NUM_LANES(N), .STACK_DEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cond_i(cond),
    .active_mask_o(mask), .skip_o(skip), .err_o(err)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic [1:0] c, logic [N-1:0] v);
    @(negedge clk);
    cmd = c; cond = v;
    @(posedge clk); #1;
    cmd = 2'b00; cond = '0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    #1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 mask", mask, 8'hFF);
    chk("R1 err", N'(err), 0);
    chk("R1 skip", N'(skip), 0);
  endtask

  task automatic t_if_else;
    op(2'b01, 8'h0F); chk("R2 then", mask, 8'h0F);
    op(2'b10, 8'h00); chk("R3 else", mask, 8'hF0);
    op(2'b11, 8'h00); chk("R4 join", mask, 8'hFF);
  endtask

  task automatic t_uniform;
    op(2'b01, 8'hFF); chk("R5 then all", mask, 8'hFF); chk("R5 no skip", N'(skip), 0);
    op(2'b10, 8'h00); chk("R5 else empty", mask, 8'h00); chk("R5 skip", N'(skip), 1);
    op(2'b11, 8'h00); chk("R5 join", mask, 8'hFF); chk("R5 skip clear", N'(skip), 0);
  endtask

  task automatic t_nested;
    op(2'b01, 8'h3C); chk("R6 outer", mask, 8'h3C);
    op(2'b01, 8'h0F); chk("R6 inner then", mask, 8'h0C);
    op(2'b10, 8'h00); chk("R6 inner else", mask, 8'h30);
    op(2'b11, 8'h00); chk("R6 inner join", mask, 8'h3C);
    for (int i = 0; i < 3; i++) op(2'b00, 8'hFF);
    chk("R10 idle hold", mask, 8'h3C);
    op(2'b10, 8'h00); chk("R6 outer else", mask, 8'hC3);
    op(2'b11, 8'h00); chk("R6 outer join", mask, 8'hFF);
    chk("R6 no err", N'(err), 0);
  endtask

  task automatic t_overflow;
    op(2'b01, 8'hAA); chk("R7 d1", mask, 8'hAA);
    op(2'b01, 8'h0F); chk("R7 d2", mask, 8'h0A);
    op(2'b01, 8'h03); chk("R7 d3", mask, 8'h02);
    op(2'b01, 8'h01); chk("R7 d4", mask, 8'h00);
    chk("R7 skip at d4", N'(skip), 1);
    op(2'b01, 8'hFF);
    chk("R7 err", N'(err), 1);
    chk("R7 mask kept", mask, 8'h00);
    chk("R7 skip kept", N'(skip), 1);
    op(2'b11, 8'h00); chk("R7 pop4", mask, 8'h02);
    op(2'b11, 8'h00); chk("R7 pop3", mask, 8'h0A);
    op(2'b11, 8'h00); chk("R7 pop2", mask, 8'hAA);
    op(2'b11, 8'h00); chk("R7 pop1", mask, 8'hFF);
    chk("R9 err sticky", N'(err), 1);
    do_reset();
    chk("R9 err cleared by reset", N'(err), 0);
  endtask

  task automatic t_underflow;
    do_reset();
    op(2'b11, 8'h00);
    chk("R8 pop empty err", N'(err), 1);
    chk("R8 pop empty mask", mask, 8'hFF);
    op(2'b01, 8'h0F); op(2'b11, 8'h00);
    chk("R9 err held", N'(err), 1);
    do_reset();
    op(2'b10, 8'h00);
    chk("R8 else empty err", N'(err), 1);
    chk("R8 else empty mask", mask, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_if_else();
    t_uniform();
    t_nested();
    t_overflow();
    t_underflow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule